// File: doc/BRIEF.md
# Static Asynchronous External Bus Controller

This block turns single read or write requests from an internal port into static asynchronous cycles on an external parallel bus. That bus serves memories and peripherals. On the internal side the requester holds a request steady until the block acknowledges it. The request carries a 24-bit address, write data, a write flag, byte enables and a chip-select index. On the external side the block drives four active-low chip selects, an address latch enable, a read strobe and two byte write strobes. It also drives dedicated address lines and a data/address bus, which is split into out, in and output-enable signals.

Configuration inputs choose three things: a data path of 8 or 16 bits, either multiplexed or separate address and data, and the read and write strobe wait counts. The block copies these settings when it accepts a request and keeps them for that whole cycle.

Every cycle runs the same sequence. The chip select asserts, followed by one address setup cycle. In multiplexed mode one address latch enable cycle comes next. The strobe is then low for 1+N cycles, followed by one hold cycle with the chip select still low. In the last cycle the chip select is released and the acknowledge is high.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is held, all chip selects, the read strobe and both write strobes are high, the address latch enable is low, the bus output enable is low, and the acknowledge is low.
- R2: At most one chip select is low at any time. The one that is low is bus_cs_n[req_cs], and it stays low from the setup cycle through the hold cycle. The acknowledge is high for one cycle, and in that cycle all chip selects are high.
- R3: In separate mode, the setup phase lasts one cycle with no latch enable pulse. bus_alo carries address bits 15:0 during the cycle. bus_ahi carries address bits 23:16 in every cycle while the chip select is low, in both modes.
- R4: In multiplexed mode, one setup cycle is followed by exactly one cycle with bus_ale high, and the strobe starts right after it. In both of these cycles bus_ad_out carries address bits 15:0 with bus_ad_oe high.
- R5: A read holds bus_rd_n low for cfg_rd_wait+1 cycles. The bus is sampled on the last of these cycles, and the sampled value is on rsp_rdata by the time the acknowledge is high.
- R6: A write holds its byte strobes low for cfg_wr_wait+1 cycles. A read never overlaps a write strobe.
- R7: In 16-bit mode (cfg_wide=1), bus_wrl_n follows req_be[0] and bus_wrh_n follows req_be[1]. In 8-bit mode, bus_wrh_n stays high, bus_ad_out[15:8] is zero during data phases, and rsp_rdata[15:8] is zero.
- R8: During a write, bus_ad_out holds the write data with bus_ad_oe high for the whole strobe and for the hold cycle.
- R9: During a read, bus_ad_oe is low for the whole strobe and for the hold cycle.
- R10: Exactly one cycle with the chip select low and no strobe active follows the strobe.
- R11: A request is accepted only in idle, and each request gets exactly one acknowledge. Between cycles, no strobe and no latch enable is active.
- R12: The configuration is copied when a request is accepted. A change made at the accepting clock edge applies to that cycle. A change made while a cycle is in progress applies only from the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wide | input | 1 | 1 selects a 16-bit data path, 0 selects 8-bit |
| cfg_mux | input | 1 | 1 selects multiplexed address/data |
| cfg_rd_wait | input | 4 | Extra read strobe cycles |
| cfg_wr_wait | input | 4 | Extra write strobe cycles |
| req_valid | input | 1 | Request present, held until acknowledged |
| req_write | input | 1 | 1 for a write |
| req_cs | input | 2 | Chip-select index |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables (bit 0 is the low byte) |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data |
| bus_cs_n | output | 4 | Active-low chip selects |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wrl_n | output | 1 | Active-low low-byte (or only) write strobe |
| bus_wrh_n | output | 1 | Active-low high-byte write strobe |
| bus_ahi | output | 8 | Address bits 23:16 |
| bus_alo | output | 16 | Address bits 15:0 in separate mode |
| bus_ad_out | output | 16 | Data/address bus, driven value |
| bus_ad_in | input | 16 | Data/address bus, received value |
| bus_ad_oe | output | 1 | Data/address bus output enable |

## Verification
A configuration update and the acceptance of a new request can happen at the same clock edge, and a configuration update can also arrive while a cycle is in progress. The driver provokes both cases. In the first, it applies new settings together with req_valid. In the second, it swaps the bus width, the mode and both wait counts one cycle after acceptance. The scoreboard judges each cycle only against the settings that were in place at acceptance: setup length, latch enable count, strobe length, active byte lanes and read data. The external memory model presents valid data only on the final strobe cycle, so sampling on any other cycle returns a wrong value.

// File: rtl/xbus_pkg.sv
// Shared types for the external bus controller.
package xbus_pkg;
    // Phases of one external cycle, in the order they occur.
    typedef enum logic [2:0] {
        XB_IDLE,
        XB_SETUP,
        XB_ALE,
        XB_STROBE,
        XB_HOLD,
        XB_DONE
    } xb_state_e;
endpackage

// File: rtl/xbus_seq.sv
// Cycle sequencer. It accepts one request in idle and copies the request and
// the configuration. It then steps through setup, an optional latch-enable
// phase, the strobe phase, hold and done.
// Assumes the requester holds req_* stable until req_ack.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int CS_N   = 4,
    parameter int WAIT_W = 4,
    localparam int CS_W  = $clog2(CS_N),
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic              cfg_mux,
    input  logic [WAIT_W-1:0] cfg_rd_wait,
    input  logic [WAIT_W-1:0] cfg_wr_wait,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output xb_state_e         st,
    output logic              last_beat,
    output logic              x_write,
    output logic [CS_W-1:0]   x_cs,
    output logic [ADDR_W-1:0] x_addr,
    output logic [DATA_W-1:0] x_wdata,
    output logic [LANES-1:0]  x_be,
    output logic              x_wide,
    output logic              x_mux
);
    logic [WAIT_W-1:0] x_wait;
    logic [WAIT_W-1:0] cnt;

    // The strobe ends when the beat counter reaches the copied wait count.
    assign last_beat = (st == XB_STROBE) && (cnt == x_wait);

    // Phase progression, with request and configuration copied at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= XB_IDLE;
            cnt     <= '0;
            x_wait  <= '0;
            x_write <= 1'b0;
            x_cs    <= '0;
            x_addr  <= '0;
            x_wdata <= '0;
            x_be    <= '0;
            x_wide  <= 1'b0;
            x_mux   <= 1'b0;
        end else begin
            case (st)
                XB_IDLE: if (req_valid) begin
                    st      <= XB_SETUP;
                    cnt     <= '0;
                    x_wait  <= req_write ? cfg_wr_wait : cfg_rd_wait;
                    x_write <= req_write;
                    x_cs    <= req_cs;
                    x_addr  <= req_addr;
                    x_wdata <= req_wdata;
                    x_be    <= req_be;
                    x_wide  <= cfg_wide;
                    x_mux   <= cfg_mux;
                end
                XB_SETUP:  st <= x_mux ? XB_ALE : XB_STROBE;
                XB_ALE:    st <= XB_STROBE;
                XB_STROBE: begin
                    if (cnt == x_wait) st <= XB_HOLD;
                    else               cnt <= cnt + 1'b1;
                end
                XB_HOLD:   st <= XB_DONE;
                default:   st <= XB_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xbus_pins.sv
// Pin decoder and read capture. It derives every external pin from the current
// phase and the copied request. It also latches read data on the last strobe
// beat. Assumes at most two byte lanes are exposed as separate strobes by the top.
module xbus_pins
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int CS_N   = 4,
    localparam int CS_W  = $clog2(CS_N),
    localparam int LANES = DATA_W / 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xb_state_e         st,
    input  logic              last_beat,
    input  logic              x_write,
    input  logic [CS_W-1:0]   x_cs,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic [DATA_W-1:0] x_wdata,
    input  logic [LANES-1:0]  x_be,
    input  logic              x_wide,
    input  logic              x_mux,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic [CS_N-1:0]   bus_cs_n,
    output logic              bus_ale,
    output logic              bus_rd_n,
    output logic [LANES-1:0]  wr_n,
    output logic [HI_W-1:0]   bus_ahi,
    output logic [DATA_W-1:0] bus_alo,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic              active, addr_ph, data_ph, strobe;
    logic [DATA_W-1:0] wr_lane, rd_lane;

    // Phase groups used by the pin equations.
    always_comb begin
        active  = (st != XB_IDLE) && (st != XB_DONE);
        addr_ph = (st == XB_SETUP) || (st == XB_ALE);
        data_ph = (st == XB_STROBE) || (st == XB_HOLD);
        strobe  = (st == XB_STROBE);
    end

    // One decoded chip select per external region.
    for (genvar i = 0; i < CS_N; i++) begin : g_cs
        assign bus_cs_n[i] = !(active && (x_cs == CS_W'(i)));
    end

    // Byte lanes: lane 0 is always present, upper lanes only in wide mode.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (k == 0) begin : g_base
            assign wr_n[k]          = !(strobe && x_write && x_be[k]);
            assign wr_lane[7:0]     = x_wdata[7:0];
            assign rd_lane[7:0]     = bus_ad_in[7:0];
        end else begin : g_upper
            assign wr_n[k]          = !(strobe && x_write && x_be[k] && x_wide);
            assign wr_lane[k*8+:8]  = x_wide ? x_wdata[k*8+:8] : 8'h00;
            assign rd_lane[k*8+:8]  = x_wide ? bus_ad_in[k*8+:8] : 8'h00;
        end
    end

    // Address, strobe and bus-drive equations.
    always_comb begin
        bus_ale  = (st == XB_ALE);
        bus_rd_n = !(strobe && !x_write);
        bus_ahi  = active ? x_addr[ADDR_W-1:DATA_W] : '0;
        bus_alo  = (active && !x_mux) ? x_addr[DATA_W-1:0] : '0;
        if (addr_ph && x_mux) begin
            bus_ad_out = x_addr[DATA_W-1:0];
            bus_ad_oe  = 1'b1;
        end else if (data_ph && x_write) begin
            bus_ad_out = wr_lane;
            bus_ad_oe  = 1'b1;
        end else begin
            bus_ad_out = '0;
            bus_ad_oe  = 1'b0;
        end
    end

    // Read data capture on the final strobe beat.
    always_ff @(posedge clk) begin
        if (!rst_n)                                rsp_rdata <= '0;
        else if (strobe && !x_write && last_beat) rsp_rdata <= rd_lane;
    end
endmodule

// File: rtl/xbus_ctrl.sv
// Top of the static asynchronous external bus controller. It joins the cycle
// sequencer and the pin decoder and maps byte-lane strobes to the low and high
// write pins. Assumes DATA_W is 16 (two byte lanes).
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int CS_N   = 4,
    parameter int WAIT_W = 4,
    localparam int CS_W  = $clog2(CS_N),
    localparam int LANES = DATA_W / 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic              cfg_mux,
    input  logic [WAIT_W-1:0] cfg_rd_wait,
    input  logic [WAIT_W-1:0] cfg_wr_wait,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              req_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [CS_N-1:0]   bus_cs_n,
    output logic              bus_ale,
    output logic              bus_rd_n,
    output logic              bus_wrl_n,
    output logic              bus_wrh_n,
    output logic [HI_W-1:0]   bus_ahi,
    output logic [DATA_W-1:0] bus_alo,
    output logic [DATA_W-1:0] bus_ad_out,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic              bus_ad_oe
);
    xb_state_e         st;
    logic              last_beat, x_write, x_wide, x_mux;
    logic [CS_W-1:0]   x_cs;
    logic [ADDR_W-1:0] x_addr;
    logic [DATA_W-1:0] x_wdata;
    logic [LANES-1:0]  x_be, wr_n;

    xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_N(CS_N), .WAIT_W(WAIT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_mux(cfg_mux),
        .cfg_rd_wait(cfg_rd_wait), .cfg_wr_wait(cfg_wr_wait),
        .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .st(st), .last_beat(last_beat), .x_write(x_write), .x_cs(x_cs),
        .x_addr(x_addr), .x_wdata(x_wdata), .x_be(x_be), .x_wide(x_wide), .x_mux(x_mux)
    );

    xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_N(CS_N)) u_pins (
        .clk(clk), .rst_n(rst_n), .st(st), .last_beat(last_beat),
        .x_write(x_write), .x_cs(x_cs), .x_addr(x_addr), .x_wdata(x_wdata),
        .x_be(x_be), .x_wide(x_wide), .x_mux(x_mux), .bus_ad_in(bus_ad_in),
        .bus_cs_n(bus_cs_n), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .wr_n(wr_n),
        .bus_ahi(bus_ahi), .bus_alo(bus_alo), .bus_ad_out(bus_ad_out),
        .bus_ad_oe(bus_ad_oe), .rsp_rdata(rsp_rdata)
    );

    // Completion pulse and byte-strobe pin mapping.
    assign req_ack   = (st == XB_DONE);
    assign bus_wrl_n = wr_n[0];
    assign bus_wrh_n = wr_n[LANES-1];
endmodule

// File: rtl/xbus_ctrl_chk.sv
// Protocol checker for xbus_ctrl. It watches only the external pins and the
// acknowledge. Attached to every instance of the top module through bind.
module xbus_ctrl_chk #(
    parameter int CS_N = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [CS_N-1:0] bus_cs_n,
    input logic            bus_ale,
    input logic            bus_rd_n,
    input logic            bus_wrl_n,
    input logic            bus_wrh_n,
    input logic            bus_ad_oe,
    input logic            req_ack
);
    p_single_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~bus_cs_n) <= 1);
    p_strobe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wrl_n || !bus_wrh_n) |-> (|(~bus_cs_n)));
    p_ack_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (&bus_cs_n));
    p_ale_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (|(~bus_cs_n)));
    p_ale_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale);
    p_rw_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && (!bus_wrl_n || !bus_wrh_n)));
    p_read_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_ad_oe);
    p_hold_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd_n) |-> (|(~bus_cs_n)));
    p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.CS_N(CS_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_ale(bus_ale),
    .bus_rd_n(bus_rd_n), .bus_wrl_n(bus_wrl_n), .bus_wrh_n(bus_wrh_n),
    .bus_ad_oe(bus_ad_oe), .req_ack(req_ack)
);

// File: tb/xbus_ctrl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected shape of each cycle, and a
// pin monitor measures every cycle and compares it when the acknowledge arrives.
module xbus_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 1'b0, cfg_mux = 1'b0;
    logic [3:0]  cfg_rd_wait = '0, cfg_wr_wait = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_cs = '0, req_be = '0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ack, bus_ale, bus_rd_n, bus_wrl_n, bus_wrh_n, bus_ad_oe;
    logic [15:0] rsp_rdata, bus_alo, bus_ad_out, bus_ad_in;
    logic [3:0]  bus_cs_n;
    logic [7:0]  bus_ahi;

    typedef struct {
        logic        w;
        logic [1:0]  cs;
        logic [23:0] addr;
        logic [15:0] data;
        logic [1:0]  be;
        logic        wide;
        logic        mux;
        int          len;
    } exp_t;
    exp_t q[$];

    int checks = 0, errors = 0;
    bit finished = 0;
    // external memory model state
    logic [15:0] ext_rdata = '0;
    int          cur_len = 1;
    // monitor state
    bit          in_tx = 0, seen_strobe = 0, cs_bad = 0, data_bad = 0, oe_bad = 0, idle_bad = 0, stray = 0;
    int          setup_cnt = 0, ale_cnt = 0, rd_cnt = 0, wrl_cnt = 0, wrh_cnt = 0, hold_cnt = 0, cs_seen = 0;
    logic [15:0] addr_lo = '0;
    logic [7:0]  addr_hi = '0;

    always #2.5 clk = ~clk;

    // The memory returns valid data only on the final read strobe cycle.
    assign bus_ad_in = (!bus_rd_n && rd_cnt == cur_len) ? ext_rdata : 16'h5A5A;

    xbus_ctrl u_xbus_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_mux(cfg_mux),
        .cfg_rd_wait(cfg_rd_wait), .cfg_wr_wait(cfg_wr_wait),
        .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ack(req_ack), .rsp_rdata(rsp_rdata), .bus_cs_n(bus_cs_n),
        .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wrl_n(bus_wrl_n),
        .bus_wrh_n(bus_wrh_n), .bus_ahi(bus_ahi), .bus_alo(bus_alo),
        .bus_ad_out(bus_ad_out), .bus_ad_in(bus_ad_in), .bus_ad_oe(bus_ad_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_view(input logic [15:0] d, input logic wide);
        return wide ? d : {8'h00, d[7:0]};
    endfunction

    // Driver: queue the expectation, present config and request together,
    // optionally disturb the config mid-cycle, then wait for the acknowledge.
    task automatic xfer(input logic w, input logic [1:0] cs, input logic [23:0] addr,
                        input logic [15:0] data, input logic [1:0] be, input logic wide,
                        input logic mux, input logic [3:0] waitc, input bit mid);
        exp_t e;
        e.w = w; e.cs = cs; e.addr = addr; e.data = data; e.be = be;
        e.wide = wide; e.mux = mux; e.len = int'(waitc) + 1;
        q.push_back(e);
        @(negedge clk);
        cur_len = e.len;
        if (!w) ext_rdata = data;
        cfg_wide = wide; cfg_mux = mux;
        cfg_rd_wait = w ? 4'd0 : waitc;
        cfg_wr_wait = w ? waitc : 4'd0;
        req_write = w; req_cs = cs; req_addr = addr; req_wdata = data; req_be = be;
        req_valid = 1'b1;
        @(negedge clk);
        if (mid) begin   // R12: mid-cycle change must not affect this cycle
            cfg_wide = !wide; cfg_mux = !mux;
            cfg_rd_wait = ~waitc; cfg_wr_wait = ~waitc;
        end
        while (!req_ack) @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: measure each external cycle and compare at the acknowledge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit strobe_now;
            strobe_now = !bus_rd_n || !bus_wrl_n || !bus_wrh_n;
            if (bus_cs_n != 4'hF) begin
                in_tx = 1;
                if ($countones(~bus_cs_n) != 1) cs_bad = 1;
                for (int i = 0; i < 4; i++) if (!bus_cs_n[i]) cs_seen = i;
                if (q.size() == 0) stray = 1;
                else begin
                    exp_t c;
                    c = q[0];
                    if (!seen_strobe && !strobe_now) begin
                        setup_cnt++;
                        if (c.mux) begin
                            addr_lo = bus_ad_out;
                            if (!bus_ad_oe) oe_bad = 1;
                        end
                        if (bus_ale) ale_cnt++;
                    end else if (strobe_now) begin
                        seen_strobe = 1;
                        if (!bus_rd_n)  rd_cnt++;
                        if (!bus_wrl_n) wrl_cnt++;
                        if (!bus_wrh_n) wrh_cnt++;
                        if (!c.mux) addr_lo = bus_alo;
                        addr_hi = bus_ahi;
                        if (c.w) begin
                            if (!bus_ad_oe || bus_ad_out !== lane_view(c.data, c.wide)) data_bad = 1;
                        end else if (bus_ad_oe) oe_bad = 1;
                    end else begin
                        hold_cnt++;
                        if (c.w && (!bus_ad_oe || bus_ad_out !== lane_view(c.data, c.wide))) data_bad = 1;
                        if (!c.w && bus_ad_oe) oe_bad = 1;
                    end
                end
            end else begin
                if (strobe_now || bus_ale) idle_bad = 1;
                if (req_ack) begin
                    if (q.size() == 0) stray = 1;
                    else begin
                        exp_t c;
                        c = q.pop_front();
                        chk("R2 selected chip select", cs_seen, c.cs);
                        chk("R2 single chip select", cs_bad, 0);
                        chk("R3/R4 setup cycles", setup_cnt, c.mux ? 2 : 1);
                        chk("R4 latch enable pulses", ale_cnt, c.mux ? 1 : 0);
                        chk("R3/R4 low address", addr_lo, c.addr[15:0]);
                        chk("R3 high address", addr_hi, c.addr[23:16]);
                        chk("R10 hold cycles", hold_cnt, 1);
                        if (c.w) begin
                            chk("R6 low-byte strobe length", wrl_cnt, c.be[0] ? c.len : 0);
                            chk("R7 high-byte strobe length", wrh_cnt, (c.wide && c.be[1]) ? c.len : 0);
                            chk("R8 write data held", data_bad, 0);
                            chk("R6 no read during write", rd_cnt, 0);
                        end else begin
                            chk("R5 read strobe length", rd_cnt, c.len);
                            chk("R5/R7 read data", rsp_rdata, lane_view(c.data, c.wide));
                            chk("R9 bus released on read", oe_bad, 0);
                            chk("R6 no write during read", wrl_cnt + wrh_cnt, 0);
                        end
                    end
                    in_tx = 0; seen_strobe = 0; cs_bad = 0; data_bad = 0; oe_bad = 0;
                    setup_cnt = 0; ale_cnt = 0; rd_cnt = 0; wrl_cnt = 0; wrh_cnt = 0; hold_cnt = 0;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R11 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 chip selects in reset", bus_cs_n, 4'hF);
        chk("R1 strobes in reset", {bus_rd_n, bus_wrl_n, bus_wrh_n}, 3'b111);
        chk("R1 ale/oe/ack in reset", {bus_ale, bus_ad_oe, req_ack}, 3'b000);
        rst_n = 1'b1;
        // separate 8-bit read and write
        xfer(1'b0, 2'd0, 24'h12_3456, 16'hBEEF, 2'b11, 1'b0, 1'b0, 4'd0, 0);
        xfer(1'b1, 2'd1, 24'hAB_CDEF, 16'h77C3, 2'b11, 1'b0, 1'b0, 4'd2, 0);
        // multiplexed 16-bit read and writes with various lanes
        xfer(1'b0, 2'd2, 24'h80_0102, 16'hCAFE, 2'b11, 1'b1, 1'b1, 4'd3, 0);
        xfer(1'b1, 2'd3, 24'h01_FFFE, 16'h1234, 2'b11, 1'b1, 1'b1, 4'd1, 0);
        xfer(1'b1, 2'd0, 24'h7F_0001, 16'hA55A, 2'b10, 1'b1, 1'b1, 4'd0, 0);
        // separate 16-bit write with low lane only, and 8-bit multiplexed read
        xfer(1'b1, 2'd2, 24'h00_0000, 16'hF00D, 2'b01, 1'b1, 1'b0, 4'd4, 0);
        xfer(1'b0, 2'd1, 24'hFF_FFFF, 16'h9C81, 2'b11, 1'b0, 1'b1, 4'd1, 0);
        // R12: config swapped mid-cycle, then new config taken with the request
        xfer(1'b0, 2'd3, 24'h35_0A0B, 16'h6E2D, 2'b11, 1'b1, 1'b1, 4'd5, 1);
        xfer(1'b1, 2'd1, 24'h44_4444, 16'h0FF0, 2'b11, 1'b0, 1'b0, 4'd15, 1);
        xfer(1'b0, 2'd0, 24'h0C_3C00, 16'h5511, 2'b11, 1'b1, 1'b0, 4'd15, 0);
        repeat (4) @(negedge clk);
        chk("R11 every request acknowledged once", q.size(), 0);
        chk("R11 bus quiet between cycles", idle_bad, 0);
        chk("R11 no unexpected activity", stray, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule